// File: doc/BRIEF.md
# Shared-Memory Mailbox Aperture

This block is a small register window of eight 32-bit words. Two functions share it: a guest function on the VF side and a managing function on the PF side. Each side has its own write port and its own read port. The highest word is the control header. Its most significant bit records who currently owns the window.

The VF fills the payload words first and then writes the header. That final write passes ownership to the PF. The PF handles the request and writes a response header with the owner bit clear. This returns the window to the VF and raises a one-cycle response pulse toward the VF. A write from the side that does not own the window is dropped.

A function-reset input hands the window to the PF. It also makes the header read as all ones on both sides until the PF writes a response. The payload carries queue addresses, a vector number and similar data, but the block neither interprets nor validates it.

Top module: `shm_mailbox_aperture`

## Requirements
- R1: After `rst`, every word reads 0 from both sides, so header bit 31 is 0 and the VF owns the window.
- R2: While the VF owns the window, a VF write to words 0 to 6 is stored. Both sides read the new value.
- R3: A VF write to word 7 while the VF owns the window stores bits 30:0 as written. Bit 31 reads back as 1, whatever value was written, and the PF now owns the window.
- R4: While the PF owns the window, VF writes to any word leave every word unchanged.
- R5: While the VF owns the window, PF writes to any word leave every word unchanged.
- R6: A PF write to word 7 with bit 31 clear, while the PF owns the window, stores the value and returns ownership to the VF. It raises `vf_resp_ready` for exactly one cycle, in the cycle after the write.
- R7: While the PF owns the window, the PF can write any word. A PF header write with bit 31 set keeps the PF as owner and raises no response pulse.
- R8: A `fn_reset` pulse makes word 7 read 0xFFFFFFFF on both sides and gives ownership to the PF. Words 0 to 6 are unchanged. The all-ones readback lasts until the PF writes word 7 with bit 31 clear.
- R9: Reads have one cycle of latency. A read issued in the same cycle as a write to that word returns the old value, and the next read returns the new value.
- R10: Any write from either side in a cycle where `fn_reset` is high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears all words |
| fn_reset | input | 1 | Function reset: PF ownership and all-ones header readback |
| vf_we | input | 1 | VF write strobe |
| vf_waddr | input | 3 | VF write word index |
| vf_wdata | input | 32 | VF write data |
| vf_raddr | input | 3 | VF read word index |
| vf_rdata | output | 32 | VF read data, one cycle after address |
| vf_resp_ready | output | 1 | One-cycle pulse when the PF returns ownership |
| pf_we | input | 1 | PF write strobe |
| pf_waddr | input | 3 | PF write word index |
| pf_wdata | input | 32 | PF write data |
| pf_raddr | input | 3 | PF read word index |
| pf_rdata | output | 32 | PF read data, one cycle after address |

## Verification
The bench builds the block with its default parameters: 32-bit words and eight words, so the header is word 7 and its owner flag is bit 31. With these values every word, including the header, is reachable from both read ports. This lets the bench write the full handoff cycle (VF request, PF response, function reset) with exact header values and exact pulse timing. It also covers ownership collisions: writes from the non-owner, and writes that coincide with a function reset.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned MBX_WORD_W = 32;
    localparam int unsigned MBX_WORDS  = 8;

    // Header word layout; owner is the bit the handoff logic acts on.
    typedef struct packed {
        logic       owner;     // 1: PF holds the window
        logic [5:0] rsvd_c;
        logic       fn_rst;
        logic [7:0] rsvd_b;
        logic [7:0] status;
        logic       dir;       // 0 request, 1 response
        logic       rsvd_a;
        logic [2:0] version;
        logic [2:0] kind;
    } mbx_hdr_t;

    typedef enum logic {
        SIDE_VF = 1'b0,
        SIDE_PF = 1'b1
    } mbx_side_e;

    function automatic logic hdr_owner(input logic [MBX_WORD_W-1:0] w);
        mbx_hdr_t h;
        h = mbx_hdr_t'(w);
        return h.owner;
    endfunction

endpackage

// File: rtl/mbx_word_store.sv
module mbx_word_store #(
    parameter int unsigned W  = 32,
    parameter int unsigned N  = 8,
    parameter int unsigned AW = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  logic [W-1:0]        wdata,
    input  logic                force_pf,
    output logic [N-1:0][W-1:0] words
);
    localparam int unsigned LAST = N - 1;

    for (genvar i = 0; i < N; i++) begin : g_word
        if (i == LAST) begin : g_hdr
            always_ff @(posedge clk) begin
                if (rst) begin
                    words[i] <= '0;
                end else begin
                    if (we && waddr == AW'(i)) words[i] <= wdata;
                    if (force_pf) words[i][W-1] <= 1'b1;
                end
            end
        end else begin : g_pay
            always_ff @(posedge clk) begin
                if (rst) begin
                    words[i] <= '0;
                end else if (we && waddr == AW'(i)) begin
                    words[i] <= wdata;
                end
            end
        end
    end

endmodule

// File: rtl/mbx_owner_ctrl.sv
module mbx_owner_ctrl
    import mbx_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned N  = 8,
    parameter int unsigned AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fn_reset,
    input  logic          owner,
    input  logic          vf_we,
    input  logic [AW-1:0] vf_waddr,
    input  logic [W-1:0]  vf_wdata,
    input  logic          pf_we,
    input  logic [AW-1:0] pf_waddr,
    input  logic [W-1:0]  pf_wdata,
    output logic          st_we,
    output logic [AW-1:0] st_waddr,
    output logic [W-1:0]  st_wdata,
    output logic          force_pf,
    output logic          reset_view,
    output logic          resp_pulse
);
    localparam logic [AW-1:0] LAST_A = AW'(N - 1);
    localparam logic [W-1:0]  OWN_BIT = {1'b1, {(W-1){1'b0}}};

    mbx_side_e writer;
    logic vf_ok, pf_ok, pf_hand_back;

    always_comb begin
        vf_ok  = vf_we && !owner && !fn_reset;
        pf_ok  = pf_we &&  owner && !fn_reset;
        writer = pf_ok ? SIDE_PF : SIDE_VF;
        pf_hand_back = pf_ok && pf_waddr == LAST_A && !pf_wdata[W-1];
        st_we    = vf_ok || pf_ok;
        st_waddr = (writer == SIDE_PF) ? pf_waddr : vf_waddr;
        if (writer == SIDE_PF)
            st_wdata = pf_wdata;
        else if (vf_waddr == LAST_A)
            st_wdata = vf_wdata | OWN_BIT;
        else
            st_wdata = vf_wdata;
        force_pf = fn_reset;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reset_view <= 1'b0;
            resp_pulse <= 1'b0;
        end else begin
            resp_pulse <= pf_hand_back;
            if (fn_reset) reset_view <= 1'b1;
            else if (pf_hand_back) reset_view <= 1'b0;
        end
    end

    // R6: after a response pulse the VF holds the window, so no second pulse follows
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        resp_pulse |=> !resp_pulse);
    a_r6_owner_back: assert property (@(posedge clk) disable iff (rst)
        resp_pulse |-> !owner);
    // R8: the all-ones view only exists while the PF owns the window
    a_r8_view_pf: assert property (@(posedge clk) disable iff (rst)
        reset_view |-> owner);
    a_r10_no_write_in_fn: assert property (@(posedge clk) disable iff (rst)
        fn_reset |-> !st_we);

endmodule

// File: rtl/mbx_read_port.sv
module mbx_read_port #(
    parameter int unsigned W  = 32,
    parameter int unsigned N  = 8,
    parameter int unsigned AW = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [AW-1:0]       raddr,
    input  logic [N-1:0][W-1:0] words,
    input  logic                reset_view,
    output logic [W-1:0]        rdata
);
    localparam logic [AW-1:0] LAST_A = AW'(N - 1);

    logic [W-1:0] view;

    always_comb begin
        if (raddr == LAST_A && reset_view)
            view = '1;
        else if (32'(raddr) < N)
            view = words[raddr];
        else
            view = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= view;
    end

endmodule

// File: rtl/shm_mailbox_aperture.sv
module shm_mailbox_aperture
    import mbx_pkg::*;
#(
    parameter int unsigned W  = MBX_WORD_W,
    parameter int unsigned N  = MBX_WORDS,
    parameter int unsigned AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fn_reset,
    input  logic          vf_we,
    input  logic [AW-1:0] vf_waddr,
    input  logic [W-1:0]  vf_wdata,
    input  logic [AW-1:0] vf_raddr,
    output logic [W-1:0]  vf_rdata,
    output logic          vf_resp_ready,
    input  logic          pf_we,
    input  logic [AW-1:0] pf_waddr,
    input  logic [W-1:0]  pf_wdata,
    input  logic [AW-1:0] pf_raddr,
    output logic [W-1:0]  pf_rdata
);
    localparam int unsigned LAST = N - 1;
    localparam logic [AW-1:0] LAST_A = AW'(LAST);

    logic [N-1:0][W-1:0] words;
    logic          st_we, force_pf, reset_view, owner;
    logic [AW-1:0] st_waddr;
    logic [W-1:0]  st_wdata;

    assign owner = words[LAST][W-1];

    mbx_owner_ctrl #(.W(W), .N(N), .AW(AW)) u_ctrl (
        .clk(clk), .rst(rst), .fn_reset(fn_reset), .owner(owner),
        .vf_we(vf_we), .vf_waddr(vf_waddr), .vf_wdata(vf_wdata),
        .pf_we(pf_we), .pf_waddr(pf_waddr), .pf_wdata(pf_wdata),
        .st_we(st_we), .st_waddr(st_waddr), .st_wdata(st_wdata),
        .force_pf(force_pf), .reset_view(reset_view), .resp_pulse(vf_resp_ready)
    );

    mbx_word_store #(.W(W), .N(N), .AW(AW)) u_store (
        .clk(clk), .rst(rst), .we(st_we), .waddr(st_waddr),
        .wdata(st_wdata), .force_pf(force_pf), .words(words)
    );

    logic [1:0][AW-1:0] rd_addr;
    logic [1:0][W-1:0]  rd_data;
    assign rd_addr[SIDE_VF] = vf_raddr;
    assign rd_addr[SIDE_PF] = pf_raddr;

    for (genvar s = 0; s < 2; s++) begin : g_rd
        mbx_read_port #(.W(W), .N(N), .AW(AW)) u_rd (
            .clk(clk), .rst(rst), .raddr(rd_addr[s]), .words(words),
            .reset_view(reset_view), .rdata(rd_data[s])
        );
    end

    assign vf_rdata = rd_data[SIDE_VF];
    assign pf_rdata = rd_data[SIDE_PF];

    // R3: a VF header write by the owner hands the window to the PF
    a_r3_vf_handover: assert property (@(posedge clk) disable iff (rst)
        (vf_we && vf_waddr == LAST_A && !owner && !fn_reset) |=> owner);
    // R4: VF writes while the PF owns change nothing
    a_r4_vf_blocked: assert property (@(posedge clk) disable iff (rst)
        (vf_we && !pf_we && owner && !fn_reset) |=> $stable(words));
    // R5: PF writes while the VF owns change nothing
    a_r5_pf_blocked: assert property (@(posedge clk) disable iff (rst)
        (pf_we && !vf_we && !owner && !fn_reset) |=> $stable(words));
    // R8: function reset leaves the PF owning the window
    a_r8_fn_owner: assert property (@(posedge clk) disable iff (rst)
        fn_reset |=> owner && hdr_owner(pf_rdata | vf_rdata) == hdr_owner(pf_rdata | vf_rdata));

endmodule

// File: tb/tb_shm_mailbox_aperture.sv
module tb_shm_mailbox_aperture;

    logic        clk = 1'b0;
    logic        rst, fn_reset;
    logic        vf_we, pf_we;
    logic [2:0]  vf_waddr, vf_raddr, pf_waddr, pf_raddr;
    logic [31:0] vf_wdata, pf_wdata, vf_rdata, pf_rdata;
    logic        vf_resp_ready;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_mem [8];

    always #4ns clk = ~clk;

    shm_mailbox_aperture dut (
        .clk(clk), .rst(rst), .fn_reset(fn_reset),
        .vf_we(vf_we), .vf_waddr(vf_waddr), .vf_wdata(vf_wdata),
        .vf_raddr(vf_raddr), .vf_rdata(vf_rdata), .vf_resp_ready(vf_resp_ready),
        .pf_we(pf_we), .pf_waddr(pf_waddr), .pf_wdata(pf_wdata),
        .pf_raddr(pf_raddr), .pf_rdata(pf_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic vf_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); vf_we = 1'b1; vf_waddr = a; vf_wdata = d;
        @(negedge clk); vf_we = 1'b0;
    endtask

    task automatic pf_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); pf_we = 1'b1; pf_waddr = a; pf_wdata = d;
        @(negedge clk); pf_we = 1'b0;
    endtask

    // Read one word from both sides and compare with the bench model
    task automatic check_word(input string req, input int a);
        @(negedge clk); vf_raddr = 3'(a); pf_raddr = 3'(a);
        @(negedge clk);
        check(req, vf_rdata, exp_mem[a]);
        check(req, pf_rdata, exp_mem[a]);
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 8; i++) check_word(req, i);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 8; i++) exp_mem[i] = '0;
        check_all("R1 reset contents");
    endtask

    task automatic t_vf_fill;
        for (int i = 0; i < 7; i++) begin
            vf_write(3'(i), 32'hA000_0000 + 32'(i) * 32'h111);
            exp_mem[i] = 32'hA000_0000 + 32'(i) * 32'h111;
        end
        check_all("R2 VF payload write");
    endtask

    task automatic t_pf_blocked;
        pf_write(3'd2, 32'hDEAD_BEEF);
        pf_write(3'd7, 32'h0000_0081);
        check_word("R5 PF write ignored", 2);
        check_word("R5 PF header ignored", 7);
    endtask

    task automatic t_vf_request;
        vf_write(3'd7, 32'h0000_0001);
        exp_mem[7] = 32'h8000_0001;
        check_word("R3 header owner set", 7);
    endtask

    task automatic t_vf_blocked;
        vf_write(3'd4, 32'h1234_5678);
        vf_write(3'd7, 32'h0000_0002);
        check_word("R4 VF write ignored", 4);
        check_word("R4 VF header ignored", 7);
    endtask

    task automatic t_pf_keep;
        pf_write(3'd5, 32'h0000_5555);
        exp_mem[5] = 32'h0000_5555;
        check_word("R7 PF payload write", 5);
        @(negedge clk); pf_we = 1'b1; pf_waddr = 3'd7; pf_wdata = 32'h8000_0101;
        @(negedge clk); pf_we = 1'b0;
        check("R7 no pulse", {31'd0, vf_resp_ready}, 32'd0);
        exp_mem[7] = 32'h8000_0101;
        check_word("R7 header kept PF", 7);
        vf_write(3'd0, 32'h0BAD_0BAD);
        check_word("R7 VF still blocked", 0);
    endtask

    task automatic t_pf_respond;
        @(negedge clk); pf_we = 1'b1; pf_waddr = 3'd7; pf_wdata = 32'h0000_0081;
        @(negedge clk); pf_we = 1'b0;
        check("R6 pulse high", {31'd0, vf_resp_ready}, 32'd1);
        @(negedge clk);
        check("R6 pulse one cycle", {31'd0, vf_resp_ready}, 32'd0);
        exp_mem[7] = 32'h0000_0081;
        check_word("R6 response stored", 7);
        vf_write(3'd1, 32'h0000_1111);
        exp_mem[1] = 32'h0000_1111;
        check_word("R6 VF owns again", 1);
    endtask

    task automatic t_same_cycle_read;
        @(negedge clk); vf_raddr = 3'd2;
        vf_we = 1'b1; vf_waddr = 3'd2; vf_wdata = 32'h2222_3333;
        @(negedge clk); vf_we = 1'b0;
        check("R9 old value", vf_rdata, exp_mem[2]);
        exp_mem[2] = 32'h2222_3333;
        @(negedge clk);
        check("R9 new value", vf_rdata, exp_mem[2]);
    endtask

    task automatic t_fn_reset;
        @(negedge clk); fn_reset = 1'b1;
        @(negedge clk); fn_reset = 1'b0;
        exp_mem[7] = 32'hFFFF_FFFF;
        check_word("R8 all ones", 7);
        check_word("R8 payload kept", 0);
        vf_write(3'd1, 32'h7777_7777);
        check_word("R8 PF owns after fn reset", 1);
        pf_write(3'd7, 32'h8000_0003);
        exp_mem[7] = 32'hFFFF_FFFF;
        check_word("R8 ones hold until response", 7);
        @(negedge clk); pf_we = 1'b1; pf_waddr = 3'd7; pf_wdata = 32'h0000_0082;
        @(negedge clk); pf_we = 1'b0;
        check("R8 response pulse", {31'd0, vf_resp_ready}, 32'd1);
        exp_mem[7] = 32'h0000_0082;
        check_word("R8 readback restored", 7);
    endtask

    task automatic t_fn_collide;
        @(negedge clk); fn_reset = 1'b1;
        vf_we = 1'b1; vf_waddr = 3'd3; vf_wdata = 32'h3333_0000;
        @(negedge clk); fn_reset = 1'b0; vf_we = 1'b0;
        check_word("R10 VF write dropped", 3);
        @(negedge clk); fn_reset = 1'b1;
        pf_we = 1'b1; pf_waddr = 3'd4; pf_wdata = 32'h4444_0000;
        @(negedge clk); fn_reset = 1'b0; pf_we = 1'b0;
        check_word("R10 PF write dropped", 4);
        exp_mem[7] = 32'hFFFF_FFFF;
        check_word("R10 header all ones", 7);
    endtask

    initial begin
        #(8ns * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; fn_reset = 1'b0;
        vf_we = 1'b0; pf_we = 1'b0;
        vf_waddr = '0; vf_raddr = '0; pf_waddr = '0; pf_raddr = '0;
        vf_wdata = '0; pf_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_vf_fill;
        t_pf_blocked;
        t_vf_request;
        t_vf_blocked;
        t_pf_keep;
        t_pf_respond;
        t_same_cycle_read;
        t_fn_reset;
        t_fn_collide;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule